// File: doc/BRIEF.md
# Integer Execute Unit with Status Flags

This block is the combinational integer execute stage of a small load/store CPU. Each cycle it takes two register operands, each with its register index, plus a 16-bit immediate, an immediate-select bit and a 3-bit operation code. From these it produces a 32-bit result. Register index 0 is hard-wired to zero: a source named by index 0 is treated as zero, whatever value is on its data input. When the immediate is selected, it replaces the second register operand. It is sign-extended for add and subtract and zero-extended for every other operation.

The unit performs add, subtract, the three bitwise logic operations, and three shifts: logical left, logical right and arithmetic right. Along with the result it reports five status flags, each on its own output. The flags are carry (borrow for subtract), overflow, zero, sign and odd parity. They are also packed into a 32-bit flag word that the surrounding pipeline can write back as one value. Multiply, divide, the register file and flag write-back sequencing belong elsewhere.

Top module: `alu_exec`

## Requirements
- R1: With op_sel = 3'b000 (add), result is A + B modulo 2^32 and flag_c is the carry out of bit 31.
- R2: With op_sel = 3'b001 (subtract), result is A - B modulo 2^32 and flag_c is set exactly when A < B as unsigned numbers (borrow).
- R3: flag_v is set on add when A and B share a sign bit that differs from the result's sign bit. It is set on subtract when A and B have different sign bits and the result's sign bit differs from A's.
- R4: op_sel = 3'b010, 3'b011 and 3'b100 give A XOR B, A OR B and A AND B respectively, with flag_c and flag_v cleared.
- R5: op_sel = 3'b101, 3'b110 and 3'b111 give logical left, logical right and arithmetic right shifts of A. The shift count is the low 5 bits of B, and the arithmetic right shift fills with A's bit 31.
- R6: Every shift operation clears flag_c and flag_v.
- R7: flag_z is set exactly when the result is zero, and flag_n equals bit 31 of the result.
- R8: flag_p is set exactly when the result holds an odd number of one bits.
- R9: An operand whose index input is 0 is taken as zero, regardless of a_val or b_val.
- R10: When use_imm is 1, B is imm: sign-extended to 32 bits for add and subtract, and zero-extended for all other operations. b_idx and b_val are then ignored.
- R11: flag_word holds carry in bit 0, overflow in bit 1, zero in bit 2, sign in bit 3 and parity in bit 4. Bits 31 down to 5 are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 3 | Operation code (encoding in R1 to R5) |
| use_imm | input | 1 | 1 selects the immediate as operand B |
| a_idx | input | 4 | Register index of operand A |
| a_val | input | 32 | Register value of operand A |
| b_idx | input | 4 | Register index of operand B |
| b_val | input | 32 | Register value of operand B |
| imm | input | 16 | Instruction immediate |
| result | output | 32 | Operation result |
| flag_c | output | 1 | Carry / borrow |
| flag_v | output | 1 | Signed overflow |
| flag_z | output | 1 | Result is zero |
| flag_n | output | 1 | Result sign |
| flag_p | output | 1 | Result has odd parity |
| flag_word | output | 32 | Packed flag word |

## Verification
Several flags can become true in the same cycle as a wrapping result, so the bench provokes those overlaps directly. An add of all-ones and one must raise carry and zero together with a zero result. A subtract of a negative value from the largest positive value must raise borrow and overflow at once. Register-zero masking and immediate sign extension also overlap when operand A names index 0 and a negative immediate is added. The result must then equal the extended immediate. Each such vector is judged against a behavioural model on the clock after it is applied, on the result, every flag output and the packed word.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_XOR = 3'd2,
    OP_OR  = 3'd3,
    OP_AND = 3'd4,
    OP_LSL = 3'd5,
    OP_LSR = 3'd6,
    OP_ASR = 3'd7
  } alu_op_e;

  localparam int FLAG_CARRY = 0;
  localparam int FLAG_OVF   = 1;
  localparam int FLAG_ZERO  = 2;
  localparam int FLAG_SIGN  = 3;
  localparam int FLAG_ODD   = 4;
  localparam int FLAG_CNT   = 5;
endpackage

// File: rtl/alu_operand_sel.sv
module alu_operand_sel #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int IDX_W  = 4
) (
  input  logic [IDX_W-1:0]  a_idx,
  input  logic [DATA_W-1:0] a_val,
  input  logic [IDX_W-1:0]  b_idx,
  input  logic [DATA_W-1:0] b_val,
  input  logic [IMM_W-1:0]  imm,
  input  logic              use_imm,
  input  logic              sign_ext,
  output logic [DATA_W-1:0] opa,
  output logic [DATA_W-1:0] opb
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_ext;

  // Register index 0 is hard-wired to zero.
  always_comb begin
    opa = (a_idx == '0) ? '0 : a_val;
  end

  always_comb begin
    if (sign_ext) imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
    else          imm_ext = {{EXT_W{1'b0}}, imm};
  end

  always_comb begin
    if (use_imm)            opb = imm_ext;
    else if (b_idx == '0)   opb = '0;
    else                    opb = b_val;
  end
endmodule

// File: rtl/alu_barrel_shift.sv
module alu_barrel_shift #(
  parameter int DATA_W = 32,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [SH_W-1:0]   amt,
  input  logic              left,
  input  logic              arith,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] rev_in;
  logic [DATA_W-1:0] stage [SH_W+1];
  logic [DATA_W-1:0] rev_out;
  logic              fill;

  // Left shifts reuse the right-shift network on bit-reversed data.
  always_comb begin
    for (int i = 0; i < DATA_W; i++) rev_in[i] = din[DATA_W-1-i];
  end

  assign stage[0] = left ? rev_in : din;
  assign fill     = arith & ~left & din[DATA_W-1];

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stage[k+1] = amt[k] ? {{STEP{fill}}, stage[k][DATA_W-1:STEP]} : stage[k];
  end

  always_comb begin
    for (int i = 0; i < DATA_W; i++) rev_out[i] = stage[SH_W][DATA_W-1-i];
  end

  assign dout = left ? rev_out : stage[SH_W];
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic [DATA_W-1:0] res,
  output logic              carry,
  output logic              ovf
);
  logic              is_sub;
  logic              is_arith;
  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   sum;
  logic [DATA_W-1:0] sh_res;

  assign is_sub   = (op == OP_SUB);
  assign is_arith = (op == OP_ADD) || is_sub;
  assign b_eff    = is_sub ? ~opb : opb;

  // One adder serves add and subtract (two's complement, carry-in 1).
  assign sum = {1'b0, opa} + {1'b0, b_eff} + {{DATA_W{1'b0}}, is_sub};

  alu_barrel_shift #(.DATA_W(DATA_W)) u_shift (
    .din   (opa),
    .amt   (opb[SH_W-1:0]),
    .left  (op == OP_LSL),
    .arith (op == OP_ASR),
    .dout  (sh_res)
  );

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB:         res = sum[DATA_W-1:0];
      OP_XOR:                 res = opa ^ opb;
      OP_OR:                  res = opa | opb;
      OP_AND:                 res = opa & opb;
      OP_LSL, OP_LSR, OP_ASR: res = sh_res;
      default:                res = '0;
    endcase
  end

  always_comb begin
    if (is_arith) begin
      carry = is_sub ? ~sum[DATA_W] : sum[DATA_W];
      ovf   = (opa[DATA_W-1] == b_eff[DATA_W-1]) && (sum[DATA_W-1] != opa[DATA_W-1]);
    end else begin
      carry = 1'b0;
      ovf   = 1'b0;
    end
  end
endmodule

// File: rtl/alu_flag_pack.sv
module alu_flag_pack
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] res,
  input  logic              carry,
  input  logic              ovf,
  output logic [FLAG_CNT-1:0] flags,
  output logic [DATA_W-1:0] word
);
  always_comb begin
    flags             = '0;
    flags[FLAG_CARRY] = carry;
    flags[FLAG_OVF]   = ovf;
    flags[FLAG_ZERO]  = (res == '0);
    flags[FLAG_SIGN]  = res[DATA_W-1];
    flags[FLAG_ODD]   = ^res;
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_word
    if (i < FLAG_CNT) begin : g_live
      assign word[i] = flags[i];
    end else begin : g_zero
      assign word[i] = 1'b0;
    end
  end
endmodule

// File: rtl/alu_exec.sv
module alu_exec
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int IDX_W  = 4
) (
  input  logic [2:0]        op_sel,
  input  logic              use_imm,
  input  logic [IDX_W-1:0]  a_idx,
  input  logic [DATA_W-1:0] a_val,
  input  logic [IDX_W-1:0]  b_idx,
  input  logic [DATA_W-1:0] b_val,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] result,
  output logic              flag_c,
  output logic              flag_v,
  output logic              flag_z,
  output logic              flag_n,
  output logic              flag_p,
  output logic [DATA_W-1:0] flag_word
);
  alu_op_e             op;
  logic [DATA_W-1:0]   opa;
  logic [DATA_W-1:0]   opb;
  logic                core_c;
  logic                core_v;
  logic [FLAG_CNT-1:0] flags;

  assign op = alu_op_e'(op_sel);

  alu_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W), .IDX_W(IDX_W)) u_opsel (
    .a_idx    (a_idx),
    .a_val    (a_val),
    .b_idx    (b_idx),
    .b_val    (b_val),
    .imm      (imm),
    .use_imm  (use_imm),
    .sign_ext ((op == OP_ADD) || (op == OP_SUB)),
    .opa      (opa),
    .opb      (opb)
  );

  alu_core #(.DATA_W(DATA_W)) u_core (
    .op    (op),
    .opa   (opa),
    .opb   (opb),
    .res   (result),
    .carry (core_c),
    .ovf   (core_v)
  );

  alu_flag_pack #(.DATA_W(DATA_W)) u_flags (
    .res   (result),
    .carry (core_c),
    .ovf   (core_v),
    .flags (flags),
    .word  (flag_word)
  );

  assign flag_c = flags[FLAG_CARRY];
  assign flag_v = flags[FLAG_OVF];
  assign flag_z = flags[FLAG_ZERO];
  assign flag_n = flags[FLAG_SIGN];
  assign flag_p = flags[FLAG_ODD];
endmodule

// File: rtl/alu_exec_chk.sv
module alu_exec_chk #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int IDX_W  = 4
) (
  input logic [2:0]        op_sel,
  input logic              use_imm,
  input logic [IDX_W-1:0]  a_idx,
  input logic [IDX_W-1:0]  b_idx,
  input logic [DATA_W-1:0] b_val,
  input logic [IMM_W-1:0]  imm,
  input logic [DATA_W-1:0] opa,
  input logic [DATA_W-1:0] opb,
  input logic [DATA_W-1:0] result,
  input logic              flag_c,
  input logic              flag_v,
  input logic              flag_z,
  input logic              flag_n,
  input logic              flag_p,
  input logic [DATA_W-1:0] flag_word
);
  logic known;
  assign known = !$isunknown({op_sel, use_imm, a_idx, b_idx, b_val, imm, opa, opb});

  always_comb begin
    if (known) begin
      // R2
      borrow_flag_chk: assert (op_sel != 3'd1 || flag_c == (opa < opb))
        else $error("borrow flag wrong");
      // R4
      logic_clear_chk: assert (!(op_sel inside {3'd2, 3'd3, 3'd4}) || (!flag_c && !flag_v))
        else $error("logic op left carry/overflow set");
      // R6
      shift_clear_chk: assert (!(op_sel inside {3'd5, 3'd6, 3'd7}) || (!flag_c && !flag_v))
        else $error("shift left carry/overflow set");
      // R7
      zero_flag_chk: assert (flag_z == (result == '0))
        else $error("zero flag wrong");
      // R7
      sign_flag_chk: assert (flag_n == result[DATA_W-1])
        else $error("sign flag wrong");
      // R8
      odd_parity_chk: assert (flag_p == ($countones(result) % 2 == 1))
        else $error("parity flag wrong");
      // R9
      reg_zero_chk: assert (!(a_idx == '0 && op_sel == 3'd3 && !use_imm) ||
                            result == ((b_idx == '0) ? '0 : b_val))
        else $error("index 0 not read as zero");
      // R10
      imm_ext_chk: assert (!use_imm || opb[IMM_W-1:0] == imm &&
                           opb[DATA_W-1:IMM_W] == ((op_sel <= 3'd1 && imm[IMM_W-1]) ?
                                                   {(DATA_W-IMM_W){1'b1}} : '0))
        else $error("immediate extension wrong");
      // R11
      flag_word_chk: assert (flag_word == {{(DATA_W-5){1'b0}}, flag_p, flag_n, flag_z, flag_v, flag_c})
        else $error("flag word layout wrong");
    end
  end
endmodule

bind alu_exec alu_exec_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W), .IDX_W(IDX_W)) u_chk (
  .op_sel    (op_sel),
  .use_imm   (use_imm),
  .a_idx     (a_idx),
  .b_idx     (b_idx),
  .b_val     (b_val),
  .imm       (imm),
  .opa       (opa),
  .opb       (opb),
  .result    (result),
  .flag_c    (flag_c),
  .flag_v    (flag_v),
  .flag_z    (flag_z),
  .flag_n    (flag_n),
  .flag_p    (flag_p),
  .flag_word (flag_word)
);

// File: tb/alu_exec_bench.sv
module alu_exec_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk;
  logic        rst_n;
  logic [2:0]  op_sel;
  logic        use_imm;
  logic [3:0]  a_idx;
  logic [31:0] a_val;
  logic [3:0]  b_idx;
  logic [31:0] b_val;
  logic [15:0] imm;
  logic [31:0] result;
  logic        flag_c, flag_v, flag_z, flag_n, flag_p;
  logic [31:0] flag_word;

  int compared   = 0;
  int mismatched = 0;
  bit done       = 0;

  alu_exec u_alu_exec (
    .op_sel    (op_sel),
    .use_imm   (use_imm),
    .a_idx     (a_idx),
    .a_val     (a_val),
    .b_idx     (b_idx),
    .b_val     (b_val),
    .imm       (imm),
    .result    (result),
    .flag_c    (flag_c),
    .flag_v    (flag_v),
    .flag_z    (flag_z),
    .flag_n    (flag_n),
    .flag_p    (flag_p),
    .flag_word (flag_word)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural model: integer arithmetic, counted bits, explicit word.
  task automatic model(output logic [31:0] r, output logic [31:0] w);
    longint unsigned a, b, s;
    int ones;
    bit c, v, z, n, p;
    a = (a_idx == 0) ? 0 : a_val;
    if (use_imm) begin
      if (op_sel <= 1 && imm[15]) b = 64'hFFFF_0000 | imm;
      else                        b = imm;
    end else begin
      b = (b_idx == 0) ? 0 : b_val;
    end
    c = 0; v = 0;
    case (op_sel)
      0: begin s = a + b; r = s[31:0]; c = s[32];
               v = (a[31] == b[31]) && (r[31] != a[31]); end
      1: begin r = 32'(a - b); c = (a < b);
               v = (a[31] != b[31]) && (r[31] != a[31]); end
      2: r = 32'(a ^ b);
      3: r = 32'(a | b);
      4: r = 32'(a & b);
      5: r = 32'(a << b[4:0]);
      6: r = 32'(a >> b[4:0]);
      default: begin
        r = 32'(a >> b[4:0]);
        if (a[31]) for (int i = 0; i < b[4:0]; i++) r[31-i] = 1'b1;
      end
    endcase
    ones = 0;
    for (int i = 0; i < 32; i++) if (r[i]) ones++;
    z = (r == 0); n = r[31]; p = (ones % 2) == 1;
    w = 0;
    w[0] = c; w[1] = v; w[2] = z; w[3] = n; w[4] = p;
  endtask

  task automatic run(input string tag, input logic [2:0] op, input logic ui,
                     input logic [3:0] ai, input logic [31:0] av,
                     input logic [3:0] bi, input logic [31:0] bv, input logic [15:0] im);
    logic [31:0] er, ew, got;
    @(posedge clk);
    #1;
    op_sel = op; use_imm = ui; a_idx = ai; a_val = av; b_idx = bi; b_val = bv; imm = im;
    @(negedge clk);
    model(er, ew);
    got = {27'd0, flag_p, flag_n, flag_z, flag_v, flag_c};
    compared++;
    if (result !== er || flag_word !== ew || got !== ew) begin
      mismatched++;
      $display("FAIL %s op=%0d result=%h exp=%h flags=%h word=%h exp_word=%h",
               tag, op, result, er, got, flag_word, ew);
    end
  endtask

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      0: return "R1";
      1: return "R2";
      2, 3, 4: return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    rst_n = 1'b0;
    op_sel = 0; use_imm = 0; a_idx = 0; a_val = 0; b_idx = 0; b_val = 0; imm = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R7: all-zero inputs give a zero result, Z=1
    run("R7 zero", 3, 0, 0, 0, 0, 0, 0);
    // R1 with R7: carry and zero together
    run("R1 carry+zero", 0, 0, 1, 32'hFFFF_FFFF, 2, 32'h1, 0);
    // R3: add overflow into sign
    run("R3 add ovf", 0, 0, 1, 32'h7FFF_FFFF, 2, 32'h1, 0);
    // R3: subtract overflow, no borrow
    run("R3 sub ovf", 1, 0, 1, 32'h8000_0000, 2, 32'h1, 0);
    // R2: borrow, result all ones (even parity)
    run("R2 borrow", 1, 0, 1, 32'h1, 2, 32'h2, 0);
    // R3 with R2: borrow and overflow together
    run("R3 borrow+ovf", 1, 0, 1, 32'h7FFF_FFFF, 2, 32'hFFFF_FFFF, 0);
    run("R4 xor", 2, 0, 3, 32'hF0F0_1234, 4, 32'h0FF0_FFFF, 0);
    run("R4 and", 4, 0, 3, 32'hF0F0_1234, 4, 32'h0FF0_FFFF, 0);
    // R5: count taken from low 5 bits (33 -> 1)
    run("R5 lsl mod", 5, 0, 1, 32'h8000_0001, 2, 32'd33, 0);
    run("R5 asr fill", 7, 0, 1, 32'h8000_0000, 2, 32'd31, 0);
    run("R5 lsr", 6, 0, 1, 32'h8000_0000, 2, 32'd31, 0);
    // R6: shift with large operands keeps C,V clear
    run("R6 shift clear", 5, 0, 1, 32'hFFFF_FFFF, 2, 32'd4, 0);
    // R8: odd number of ones
    run("R8 parity", 3, 0, 1, 32'h7, 0, 0, 0);
    // R9: index 0 masks a nonzero value on either side
    run("R9 a zero", 3, 0, 0, 32'hDEAD_BEEF, 2, 32'h55, 0);
    run("R9 b zero", 0, 0, 1, 32'h10, 0, 32'hFFFF_FFFF, 0);
    // R10: sign extension for add, zero extension for or, b inputs ignored
    run("R10 sext add", 0, 1, 0, 32'h1234, 2, 32'hFFFF_FFFF, 16'h8000);
    run("R10 zext or", 3, 1, 1, 32'h0, 2, 32'hFFFF_FFFF, 16'h8000);
    run("R10 sext sub", 1, 1, 1, 32'h5, 2, 32'h0, 16'hFFFF);
    // R11: packed word checked on each vector; random sweep over all ops
    for (int k = 0; k < 400; k++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 7));
      run(tag_of(op), op, 1'($urandom_range(0, 1)), 4'($urandom_range(0, 3)), $urandom,
          4'($urandom_range(0, 3)), $urandom, 16'($urandom));
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule